// File: doc/BRIEF.md
# Priority Interrupt Controller with Nesting Stack

This block gathers a parameterized set of interrupt sources, each fed by a peripheral input and by a software-set bit. Each source has its own 4-bit priority register. The block raises a single request line to the processor whenever the best pending priority is strictly above the running priority level. All setup and servicing goes through a small word-addressed register bus.

Software services an interrupt in three steps. First it reads the acknowledge register. That read returns a table address made from a programmable base and the winning source's vector, scaled by the selected entry size. The same read lifts the running level to the winner's priority, which drops the request, and saves the old level on a 16-entry stack. When the handler is done, any write to the end-of-interrupt register takes the saved level back off the stack. This lets handlers nest cleanly.

Register words, with byte address = 4 × word:
- Word 0 is control. Bit 0 is the hardware-vector enable, which is stored and read back only. Bit 1 selects the entry size: 0 means 4-byte entries, 1 means 8-byte entries.
- Word 1 is the running level, in bits [3:0].
- Word 2 is acknowledge. A write sets the table base from bits [31:12]. A read returns the table address.
- Word 3 is end-of-interrupt.
- Words 4+i are source i. Bits [3:0] hold its priority and bit 8 is its software-set bit.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_req is 0, and the control, running-level, source and acknowledge registers all read 0. A read returns its data on bus_rdata one cycle after bus_rd.
- R2: irq_req is 1 exactly when some pending source has a priority strictly greater than the running level. Priority 0 never requests, and a priority equal to the running level does not request.
- R3: When several pending sources share the top priority, the one with the lowest index wins.
- R4: An acknowledge read returns base[31:12] with the winning index shifted left by 2 (control bit 1 = 0) or by 3 (control bit 1 = 1). With no request active, it returns just the base and changes nothing.
- R5: An acknowledge read while irq_req is 1 sets the running level to the winner's priority, so irq_req is 0 from the next cycle. It also pushes the old level onto the stack.
- R6: A write to end-of-interrupt restores the most recently pushed level, so nested acknowledges unwind in reverse order.
- R7: A write to end-of-interrupt with the stack empty sets the running level to 0.
- R8: The stack holds 16 levels. A push onto a full stack discards the oldest entry, so after 17 pushes, the 17th pop yields 0.
- R9: A source's software-set bit (bit 8 of its register) requests exactly like its peripheral input, and clearing it withdraws the request.
- R10: Control bits [1:0] and the source fields (priority [3:0], software bit 8) read back as written.
- R11: A write to the running-level register sets it directly. The level otherwise changes only on an acknowledge or an end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | N_SRC | Peripheral interrupt inputs, level |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (word = addr[ADDR_W-1:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach from the ports is overflow of the nesting stack. Only 15 nonzero levels exist, so nested acknowledges alone can never fill 16 entries. The stimulus gets around this by holding one software-set source at priority 15. Before each of 17 acknowledges, it writes a different lower running level directly. It then unwinds with 17 end-of-interrupt writes and reads the level back after each one. This shows that the oldest level was dropped and that the final pop returns 0.

// File: rtl/prio_intc_pkg.sv
// Shared constants for the priority interrupt controller.
// Assumes word addressing with byte address = 4 * word index.
package prio_intc_pkg;
    localparam int PRI_W    = 4;
    localparam int VEC_W    = 9;
    localparam int BASE_LSB = 12;
    typedef logic [PRI_W-1:0] pri_t;
    localparam int W_CTRL   = 0;
    localparam int W_LEVEL  = 1;
    localparam int W_ACK    = 2;
    localparam int W_EOI    = 3;
    localparam int W_SRC0   = 4;
endpackage

// File: rtl/intc_arbiter.sv
// Picks the pending source with the highest priority; ties go to the
// lowest index. Purely combinational. Assumes N_SRC <= 2**VEC_W.
module intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]       pending,
    input  logic [N_SRC*PRI_W-1:0] pri_flat,
    output pri_t                   best_pri,
    output logic [VEC_W-1:0]       best_vec
);
    // scan upward, accept only strictly higher so lower index keeps ties
    always_comb begin
        best_pri = '0;
        best_vec = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pending[i] && (pri_flat[i*PRI_W +: PRI_W] > best_pri)) begin
                best_pri = pri_flat[i*PRI_W +: PRI_W];
                best_vec = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_prio_lifo.sv
// Circular stack of saved priority levels. A push when full overwrites
// the oldest entry; a pop when empty yields zero on top.
// Assumes DEPTH is a power of two so the pointer wraps naturally.
module intc_prio_lifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] tptr;

    assign tptr = wptr - 1'b1;
    // top of stack, zero when empty
    assign top  = (count == '0) ? '0 : mem[tptr];

    // storage, pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wptr] <= din;
            wptr      <= wptr + 1'b1;
            if (count != CNT_W'(DEPTH)) count <= count + 1'b1;
        end else if (pop && count != '0) begin
            wptr  <= tptr;
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Priority interrupt controller top: register bus, per-source priority
// and software-set bits, running level with nesting stack, table-address
// generation on acknowledge. Assumes one bus access per cycle and
// 4 + N_SRC words fitting in ADDR_W-2 word bits.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC      = 16,
    parameter int LIFO_DEPTH = 16,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_irq,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int CNT_W  = $clog2(LIFO_DEPTH+1);
    localparam int BASE_W = 32 - BASE_LSB;

    logic [WORD_W-1:0]      word;
    logic                   hw_vec_en;
    logic                   ent8;
    logic [BASE_W-1:0]      tbl_base;
    pri_t                   cur_pri;
    logic [N_SRC*PRI_W-1:0] pri_flat;
    logic [N_SRC-1:0]       sw_set;
    logic [N_SRC-1:0]       pending;
    pri_t                   best_pri;
    logic [VEC_W-1:0]       best_vec;
    logic                   take;
    logic                   pop;
    pri_t                   lifo_top;
    logic [CNT_W-1:0]       lifo_count;
    logic [31:0]            ack_val;
    logic [31:0]            src_rd;

    assign word    = bus_addr[ADDR_W-1:2];
    assign pending = src_irq | sw_set;
    assign irq_req = (best_pri > cur_pri);
    assign take    = bus_rd && (word == WORD_W'(W_ACK)) && irq_req;
    assign pop     = bus_wr && (word == WORD_W'(W_EOI));

    intc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .pending  (pending),
        .pri_flat (pri_flat),
        .best_pri (best_pri),
        .best_vec (best_vec)
    );

    intc_prio_lifo #(.DEPTH(LIFO_DEPTH), .W(PRI_W)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (pop),
        .din   (cur_pri),
        .top   (lifo_top),
        .count (lifo_count)
    );

    // per-source priority and software-set registers
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pri_flat[g*PRI_W +: PRI_W] <= '0;
                sw_set[g]                  <= 1'b0;
            end else if (bus_wr && word == WORD_W'(W_SRC0 + g)) begin
                pri_flat[g*PRI_W +: PRI_W] <= bus_wdata[PRI_W-1:0];
                sw_set[g]                  <= bus_wdata[8];
            end
        end
    end

    // control and table base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_vec_en <= 1'b0;
            ent8      <= 1'b0;
            tbl_base  <= '0;
        end else if (bus_wr && word == WORD_W'(W_CTRL)) begin
            hw_vec_en <= bus_wdata[0];
            ent8      <= bus_wdata[1];
        end else if (bus_wr && word == WORD_W'(W_ACK)) begin
            tbl_base  <= bus_wdata[31:BASE_LSB];
        end
    end

    // running level: acknowledge raises, end-of-interrupt restores, write sets
    always_ff @(posedge clk) begin
        if (!rst_n)                                    cur_pri <= '0;
        else if (take)                                 cur_pri <= best_pri;
        else if (pop)                                  cur_pri <= lifo_top;
        else if (bus_wr && word == WORD_W'(W_LEVEL))   cur_pri <= bus_wdata[PRI_W-1:0];
    end

    // table address for the acknowledge read
    always_comb begin
        ack_val = {tbl_base, {BASE_LSB{1'b0}}};
        if (irq_req) ack_val = ack_val | (32'(best_vec) << (ent8 ? 3 : 2));
    end

    // source register read view
    always_comb begin
        src_rd = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (word == WORD_W'(W_SRC0 + i)) begin
                src_rd[PRI_W-1:0] = pri_flat[i*PRI_W +: PRI_W];
                src_rd[8]         = sw_set[i];
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (word)
                WORD_W'(W_CTRL):  bus_rdata <= {30'd0, ent8, hw_vec_en};
                WORD_W'(W_LEVEL): bus_rdata <= {{(32-PRI_W){1'b0}}, cur_pri};
                WORD_W'(W_ACK):   bus_rdata <= ack_val;
                WORD_W'(W_EOI):   bus_rdata <= '0;
                default:          bus_rdata <= src_rd;
            endcase
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Temporal checks for prio_intc, attached by bind. Observes the bus
// strobes, the request line and the running level with its stack.
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LIFO_DEPTH = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          irq_req,
    input pri_t                          cur_pri,
    input pri_t                          lifo_top,
    input logic [$clog2(LIFO_DEPTH+1)-1:0] lifo_count
);
    localparam int WORD_W = ADDR_W - 2;
    logic ack_rd, eoi_wr, lvl_wr;
    assign ack_rd = bus_rd && bus_addr[ADDR_W-1:2] == WORD_W'(W_ACK);
    assign eoi_wr = bus_wr && bus_addr[ADDR_W-1:2] == WORD_W'(W_EOI);
    assign lvl_wr = bus_wr && bus_addr[ADDR_W-1:2] == WORD_W'(W_LEVEL);

    p_ack_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_req) |=> !irq_req);

    p_ack_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && irq_req && lifo_count < LIFO_DEPTH) |=> lifo_count == $past(lifo_count) + 1'b1);

    p_eoi_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && lifo_count != 0) |=> cur_pri == $past(lifo_top));

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && lifo_count == 0) |=> cur_pri == '0);

    p_top_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pri == '1) |-> !irq_req);

    p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_rd && irq_req) && !eoi_wr && !lvl_wr |=> $stable(cur_pri));
endmodule

bind prio_intc prio_intc_chk #(.ADDR_W(ADDR_W), .LIFO_DEPTH(LIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .irq_req    (irq_req),
    .cur_pri    (cur_pri),
    .lifo_top   (lifo_top),
    .lifo_count (lifo_count)
);

// File: tb/prio_intc_tb_top.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares
// bus_rdata on the cycle it becomes valid.
module prio_intc_tb_top;
    localparam int N = 16;
    localparam logic [31:0] BASE = 32'hABCDE000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_irq = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    int checks = 0, fails = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_q = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    // monitor: note a read strobe, compare data one cycle later
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input int word, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(word * 4); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int word, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'(word * 4);
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_req(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq_req !== e) begin
            fails++;
            $display("FAIL %s: irq_req actual %b expected %b", t, irq_req, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_req(1'b0, "R1");
        rd(0, 32'h0, "R1 ctrl");
        rd(1, 32'h0, "R1 level");
        rd(4, 32'h0, "R1 src0");
        rd(2, 32'h0, "R1 ack");
        // R10 readback
        wr(0, 32'h3);
        rd(0, 32'h3, "R10 ctrl");
        wr(0, 32'h0);
        wr(7, 32'h10A);
        rd(7, 32'h10A, "R10 src3");
        wr(7, 32'h0);
        wr(2, BASE);
        // R2 strict compare, priority 0 never requests
        src_irq[5] = 1'b1;
        chk_req(1'b0, "R2 pri0");
        wr(4 + 5, 32'h3);
        chk_req(1'b1, "R2 above");
        wr(1, 32'h3);
        chk_req(1'b0, "R2 equal");
        rd(1, 32'h3, "R11 level write");
        wr(1, 32'h2);
        chk_req(1'b1, "R2 below");
        wr(1, 32'h0);
        // R3 tie at priority 6, R4 4-byte entries, R5 level raise
        wr(4 + 9, 32'h6); wr(4 + 4, 32'h6);
        src_irq[9] = 1'b1; src_irq[4] = 1'b1;
        rd(2, BASE | (32'd4 << 2), "R3 R4 ack tie");
        chk_req(1'b0, "R5 req dropped");
        rd(1, 32'h6, "R5 level raised");
        src_irq[4] = 1'b0;
        chk_req(1'b0, "R2 equal after ack");
        // R9 software set, R4 8-byte entries
        wr(4 + 3, 32'h109);
        chk_req(1'b1, "R9 sw set");
        wr(0, 32'h2);
        rd(2, BASE | (32'd3 << 3), "R4 ack 8-byte");
        rd(1, 32'h9, "R5 nested level");
        // R6 unwind, R7 empty pop
        wr(3, 32'h0);
        rd(1, 32'h6, "R6 first pop");
        wr(3, 32'h0);
        rd(1, 32'h0, "R6 second pop");
        wr(3, 32'h0);
        rd(1, 32'h0, "R7 empty pop");
        wr(4 + 3, 32'h009);
        src_irq = '0;
        wr(4 + 5, 32'h0); wr(4 + 9, 32'h0);
        chk_req(1'b0, "R9 sw cleared");
        // R8 overflow: 17 pushes via repeated level writes and acks
        wr(4 + 0, 32'h10F);
        for (int i = 0; i < 17; i++) begin
            wr(1, 32'((i % 14) + 1));
            rd(2, BASE, "R8 ack push");
        end
        for (int j = 1; j <= 16; j++) begin
            wr(3, 32'h0);
            rd(1, 32'(((17 - j) % 14) + 1), "R8 pop");
        end
        wr(3, 32'h0);
        rd(1, 32'h0, "R8 oldest discarded");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule